// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen 32-bit architectural registers of a processor core and presents a different physical copy of some of them depending on the current 5-bit operating mode. Two combinational read ports and one clocked write port carry ordinary operand traffic. A separate port reads the program counter every cycle and may overwrite it, so the fetch logic can advance the counter while the execute stage uses the general ports. Index 15 is the program counter and index 14 is the link register.

Indices 0 to 7 always reach one shared set. The fast-interrupt mode has a private copy of indices 8 to 14. The standard-interrupt, supervisor, abort and undefined modes each have only a private stack pointer (13) and link register (14), and use the user copy of 8 to 12. User and system modes use the same user set. Each of the five privileged modes other than system has a saved-status register, which is read and written through a status port that follows the current mode.

Top module: `mbrf_regfile`

## Requirements
- R1: After synchronous reset, every register read through either read port returns zero in every mode, `pc_rdata` is zero and `sts_rdata` is zero.
- R2: Read ports are combinational. A write on the general port becomes visible at the next rising edge. A read of the index being written in the same cycle returns the old value.
- R3: Indices 0 to 7 name the same physical registers in every mode, including unrecognised mode codes.
- R4: In fast-interrupt mode (`mode` = 5'b10001), indices 8 to 14 select seven registers that no other mode can reach.
- R5: Modes 5'b10010, 5'b10011, 5'b10111 and 5'b11011 each have their own private copies of indices 13 and 14. Their indices 8 to 12 reach the user copy.
- R6: User mode (5'b10000) and system mode (5'b11111) reach the same register for every index.
- R7: `pc_rdata` shows the program counter at all times, and a read of index 15 on either read port returns the same value. `pc_we` loads `pc_wdata` at the next edge. The counter keeps its value when nothing writes it.
- R8: When a general write to index 15 and `pc_we` occur in the same cycle, the general write data is stored.
- R9: Each of modes 5'b10001, 5'b10010, 5'b10011, 5'b10111 and 5'b11011 has its own saved-status register, written by `sts_we` and read on `sts_rdata`. In user and system modes, status writes are ignored and `sts_rdata` is zero.
- R10: Any mode code not listed above uses the user register set, ignores status writes and reads zero on `sts_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 5 | Current operating mode code |
| rd_a_idx | input | 4 | Read port A architectural index |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B architectural index |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | General write architectural index |
| wr_data | input | 32 | General write data |
| pc_rdata | output | 32 | Program counter, always visible |
| pc_we | input | 1 | Program counter port write enable |
| pc_wdata | input | 32 | Program counter port write data |
| sts_we | input | 1 | Saved-status write enable for the current mode |
| sts_wdata | input | 32 | Saved-status write data |
| sts_rdata | output | 32 | Saved-status register of the current mode, zero if it has none |

## Verification
A wrong mode-to-register mapping does not show when it is written. It shows only when the same index is read in another mode, and then as stale or foreign data. For that reason the bench writes distinct values into every bank and then reads every index in every mode, comparing against its own array. A lost or misdirected program-counter update shows on `pc_rdata` one edge later. A wrong saved-status slot shows as soon as the mode changes to a mode that shares the slot.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

    localparam int unsigned ARCH_REGS    = 16;
    localparam int unsigned IDX_W        = $clog2(ARCH_REGS);
    localparam int unsigned MODE_W       = 5;
    localparam int unsigned SHARED_REGS  = 8;
    localparam int unsigned FAST_BANKED  = ARCH_REGS - 1 - SHARED_REGS;
    localparam int unsigned PRIV_BANKED  = 2;
    localparam int unsigned PRIV_MODES   = 4;
    localparam int unsigned PRIV_W       = $clog2(PRIV_MODES);
    localparam int unsigned PRIV_FIRST   = ARCH_REGS - 1 - PRIV_BANKED;

    // Physical layout: shared low set, user high set, fast high set, then
    // one pair per banked privileged mode.
    localparam int unsigned USER_HI_BASE = SHARED_REGS;
    localparam int unsigned FAST_HI_BASE = USER_HI_BASE + FAST_BANKED;
    localparam int unsigned PRIV_BASE    = FAST_HI_BASE + FAST_BANKED;
    localparam int unsigned PHYS_REGS    = PRIV_BASE + PRIV_MODES * PRIV_BANKED;
    localparam int unsigned PHYS_W       = $clog2(PHYS_REGS);

    localparam int unsigned SAVED_SLOTS  = 1 + PRIV_MODES;
    localparam int unsigned SLOT_W       = $clog2(SAVED_SLOTS);

    localparam logic [IDX_W-1:0] PC_IDX  = IDX_W'(ARCH_REGS - 1);

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } cpu_mode_e;

    typedef struct packed {
        logic              fast;       // high set replaced by fast copy
        logic              priv;       // stack/link pair replaced
        logic [PRIV_W-1:0] priv_slot;  // which privileged pair
        logic              saved_ok;   // mode owns a saved-status slot
        logic [SLOT_W-1:0] saved_slot;
    } bank_sel_t;

    function automatic bank_sel_t decode_mode(logic [MODE_W-1:0] m);
        bank_sel_t s;
        s = '0;
        case (m)
            MODE_FIQ: begin
                s.fast       = 1'b1;
                s.saved_ok   = 1'b1;
                s.saved_slot = SLOT_W'(0);
            end
            MODE_IRQ: begin
                s.priv       = 1'b1;
                s.priv_slot  = PRIV_W'(0);
                s.saved_ok   = 1'b1;
                s.saved_slot = SLOT_W'(1);
            end
            MODE_SVC: begin
                s.priv       = 1'b1;
                s.priv_slot  = PRIV_W'(1);
                s.saved_ok   = 1'b1;
                s.saved_slot = SLOT_W'(2);
            end
            MODE_ABT: begin
                s.priv       = 1'b1;
                s.priv_slot  = PRIV_W'(2);
                s.saved_ok   = 1'b1;
                s.saved_slot = SLOT_W'(3);
            end
            MODE_UND: begin
                s.priv       = 1'b1;
                s.priv_slot  = PRIV_W'(3);
                s.saved_ok   = 1'b1;
                s.saved_slot = SLOT_W'(4);
            end
            default: s = '0;  // user, system and unknown codes
        endcase
        return s;
    endfunction

    function automatic logic [PHYS_W-1:0] map_phys(bank_sel_t s, logic [IDX_W-1:0] idx);
        int unsigned i;
        int unsigned loc;
        i = int'(idx);
        if (i < SHARED_REGS)
            loc = i;
        else if (s.fast)
            loc = FAST_HI_BASE + (i - SHARED_REGS);
        else if (s.priv && i >= PRIV_FIRST)
            loc = PRIV_BASE + int'(s.priv_slot) * PRIV_BANKED + (i - PRIV_FIRST);
        else
            loc = USER_HI_BASE + (i - SHARED_REGS);
        return PHYS_W'(loc);
    endfunction

endpackage

// File: rtl/mbrf_mode_decode.sv
module mbrf_mode_decode
    import mbrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_i,
    output bank_sel_t         sel_o
);

    always_comb begin
        sel_o = decode_mode(mode_i);
    end

    AST_FAST_PRIV_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(sel_o.fast && sel_o.priv))
        else $error("fast and privileged banks selected together"); // R4

    AST_USER_NO_SAVED: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_USR || mode_i == MODE_SYS) |-> (!sel_o.saved_ok && !sel_o.fast && !sel_o.priv))
        else $error("user or system mode decoded to a banked set"); // R6

endmodule

// File: rtl/mbrf_gpr_array.sv
module mbrf_gpr_array #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 30,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) cells[i] <= '0;
        end else if (we) begin
            for (int i = 0; i < int'(DEPTH); i++)
                if (waddr == AW'(i)) cells[i] <= wdata;
        end
    end

    // Combinational reads, no bypass of a same-cycle write.
    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];

    for (genvar g = 0; g < int'(DEPTH); g++) begin : g_chk
        AST_CELL_WRITE: assert property (@(posedge clk) disable iff (rst)
            (we && waddr == AW'(g)) |=> cells[g] == $past(wdata))
            else $error("cell %0d missed its write", g); // R2

        AST_CELL_HOLD: assert property (@(posedge clk) disable iff (rst)
            !(we && waddr == AW'(g)) |=> $stable(cells[g]))
            else $error("cell %0d changed without a write", g); // R2
    end

endmodule

// File: rtl/mbrf_pc_reg.sv
module mbrf_pc_reg #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gen_we,
    input  logic [DATA_W-1:0] gen_data,
    input  logic              port_we,
    input  logic [DATA_W-1:0] port_data,
    output logic [DATA_W-1:0] pc_q
);

    always_ff @(posedge clk) begin
        if (rst)          pc_q <= '0;
        else if (gen_we)  pc_q <= gen_data;   // general port has priority
        else if (port_we) pc_q <= port_data;
    end

    AST_PC_CONFLICT: assert property (@(posedge clk) disable iff (rst)
        gen_we |=> pc_q == $past(gen_data))
        else $error("general write to counter lost"); // R8

    AST_PC_PORT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (port_we && !gen_we) |=> pc_q == $past(port_data))
        else $error("counter port write lost"); // R7

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!port_we && !gen_we) |=> $stable(pc_q))
        else $error("counter changed without a write"); // R7

endmodule

// File: rtl/mbrf_saved_bank.sv
module mbrf_saved_bank #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SLOTS  = 5,
    localparam int unsigned SW    = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_ok,
    input  logic [SW-1:0]     slot,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] held [SLOTS];

    for (genvar g = 0; g < int'(SLOTS); g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                held[g] <= '0;
            else if (we && slot_ok && slot == SW'(g))
                held[g] <= wdata;
        end

        AST_SLOT_GUARD: assert property (@(posedge clk) disable iff (rst)
            (we && !slot_ok) |=> $stable(held[g]))
            else $error("saved slot %0d written by a mode without one", g); // R9
    end

    assign rdata = slot_ok ? held[slot] : '0;

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        slot_ok |-> int'(slot) < int'(SLOTS))
        else $error("saved slot index out of range"); // R9

endmodule

// File: rtl/mbrf_regfile.sv
module mbrf_regfile
    import mbrf_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        mode,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] pc_rdata,
    input  logic              pc_we,
    input  logic [DATA_W-1:0] pc_wdata,
    input  logic              sts_we,
    input  logic [DATA_W-1:0] sts_wdata,
    output logic [DATA_W-1:0] sts_rdata
);

    bank_sel_t          sel;
    logic [PHYS_W-1:0]  phys_a, phys_b, phys_w;
    logic [DATA_W-1:0]  cell_a, cell_b, pc_q;
    logic               gpr_we, pc_hit;

    mbrf_mode_decode u_decode (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode),
        .sel_o  (sel)
    );

    always_comb begin
        phys_a = map_phys(sel, rd_a_idx);
        phys_b = map_phys(sel, rd_b_idx);
        phys_w = map_phys(sel, wr_idx);
    end

    assign pc_hit = wr_en && (wr_idx == PC_IDX);
    assign gpr_we = wr_en && (wr_idx != PC_IDX);

    mbrf_gpr_array #(
        .DATA_W (DATA_W),
        .DEPTH  (PHYS_REGS)
    ) u_cells (
        .clk     (clk),
        .rst     (rst),
        .we      (gpr_we),
        .waddr   (phys_w),
        .wdata   (wr_data),
        .raddr_a (phys_a),
        .rdata_a (cell_a),
        .raddr_b (phys_b),
        .rdata_b (cell_b)
    );

    mbrf_pc_reg #(
        .DATA_W (DATA_W)
    ) u_pc (
        .clk       (clk),
        .rst       (rst),
        .gen_we    (pc_hit),
        .gen_data  (wr_data),
        .port_we   (pc_we),
        .port_data (pc_wdata),
        .pc_q      (pc_q)
    );

    mbrf_saved_bank #(
        .DATA_W (DATA_W),
        .SLOTS  (SAVED_SLOTS)
    ) u_saved (
        .clk     (clk),
        .rst     (rst),
        .slot_ok (sel.saved_ok),
        .slot    (sel.saved_slot),
        .we      (sts_we),
        .wdata   (sts_wdata),
        .rdata   (sts_rdata)
    );

    assign rd_a_data = (rd_a_idx == PC_IDX) ? pc_q : cell_a;
    assign rd_b_data = (rd_b_idx == PC_IDX) ? pc_q : cell_b;
    assign pc_rdata  = pc_q;

    AST_UNKNOWN_MODE_STATUS: assert property (@(posedge clk) disable iff (rst)
        !(mode inside {MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC, MODE_ABT, MODE_UND, MODE_SYS})
        |-> sts_rdata == '0)
        else $error("unknown mode exposed a saved status value"); // R10

    AST_PC_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == PC_IDX) |-> rd_a_data == pc_rdata)
        else $error("read of counter index disagrees with counter port"); // R7

endmodule

// File: tb/mbrf_regfile_test.sv
`timescale 1ns/1ps
module mbrf_regfile_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  mode;
    logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data, pc_rdata, pc_wdata, sts_wdata, sts_rdata;
    logic        wr_en, pc_we, sts_we;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [31:0] m_reg [31];  // 0..29 banked cells, 30 is the counter
    logic [31:0] m_sts [5];

    localparam logic [4:0] MODES [9] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                         5'b10111, 5'b11011, 5'b11111, 5'b00000, 5'b10101};

    always #4 clk = ~clk;  // 125 MHz

    mbrf_regfile uut (
        .clk(clk), .rst(rst), .mode(mode),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .pc_rdata(pc_rdata), .pc_we(pc_we), .pc_wdata(pc_wdata),
        .sts_we(sts_we), .sts_wdata(sts_wdata), .sts_rdata(sts_rdata)
    );

    // Reference location of an index in a mode, from the requirements.
    function automatic int ref_loc(logic [4:0] md, int idx);
        int k;
        if (idx == 15) return 30;
        if (idx < 8)   return idx;
        if (md == 5'b10001) return 15 + (idx - 8);
        k = -1;
        case (md)
            5'b10010: k = 0;
            5'b10011: k = 1;
            5'b10111: k = 2;
            5'b11011: k = 3;
            default:  k = -1;
        endcase
        if (k >= 0 && idx >= 13) return 22 + 2 * k + (idx - 13);
        return idx;  // user high copy
    endfunction

    function automatic int ref_sts(logic [4:0] md);
        case (md)
            5'b10001: return 0;
            5'b10010: return 1;
            5'b10011: return 2;
            5'b10111: return 3;
            5'b11011: return 4;
            default:  return -1;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(logic [4:0] md, int idx, logic [31:0] d);
        @(negedge clk);
        mode = md; wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_reg[ref_loc(md, idx)] = d;
    endtask

    task automatic look(logic [4:0] md, int idx, string tag);
        mode = md; rd_a_idx = 4'(idx); rd_b_idx = 4'(idx);
        #1;
        chk(tag, rd_a_data, m_reg[ref_loc(md, idx)]);
        chk(tag, rd_b_data, m_reg[ref_loc(md, idx)]);
    endtask

    task automatic sweep(string tag);
        @(negedge clk);
        for (int mi = 0; mi < 9; mi++)
            for (int idx = 0; idx < 16; idx++)
                look(MODES[mi], idx, tag);
    endtask

    task automatic t_reset();
        sweep("R1 reset registers");
        chk("R1 reset counter", pc_rdata, 32'h0);
        for (int mi = 0; mi < 9; mi++) begin
            mode = MODES[mi]; #1;
            chk("R1 reset status", sts_rdata, 32'h0);
        end
    endtask

    task automatic t_shared();
        for (int i = 0; i < 8; i++) put(MODES[(i * 2) % 9], i, 32'hA5A5_0000 + 32'(i));
        sweep("R3 shared low set");
    endtask

    task automatic t_banks();
        for (int mi = 0; mi < 9; mi++)
            for (int idx = 8; idx < 15; idx++)
                put(MODES[mi], idx, {8'h5B, 3'b0, MODES[mi], 8'h00, 4'h0, 4'(idx)} + 32'(mi * 16));
        sweep("R4 R5 R6 R10 banked mapping");
        // System write seen in user mode
        put(5'b11111, 13, 32'hC0DE_0013);
        @(negedge clk); look(5'b10000, 13, "R6 system to user");
        put(5'b10101, 14, 32'hBAD0_0014);
        @(negedge clk); look(5'b10000, 14, "R10 unknown mode to user");
        look(5'b10001, 14, "R4 fast copy untouched");
        look(5'b10011, 14, "R5 supervisor copy untouched");
        look(5'b10011, 10, "R5 supervisor uses user r10");
    endtask

    task automatic t_same_cycle();
        logic [31:0] old;
        @(negedge clk);
        old = m_reg[3];
        mode = 5'b10010; wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h1234_5678;
        rd_a_idx = 4'd3; rd_b_idx = 4'd3;
        #1;
        chk("R2 same-cycle read old A", rd_a_data, old);
        chk("R2 same-cycle read old B", rd_b_data, old);
        @(posedge clk); #1;
        wr_en = 1'b0;
        m_reg[3] = 32'h1234_5678;
        chk("R2 write visible after edge", rd_a_data, 32'h1234_5678);
    endtask

    task automatic t_pc();
        @(negedge clk);
        pc_we = 1'b1; pc_wdata = 32'h0000_1000;
        @(negedge clk);
        pc_we = 1'b0; m_reg[30] = 32'h0000_1000;
        chk("R7 counter port load", pc_rdata, 32'h0000_1000);
        look(5'b10001, 15, "R7 read index 15 fast");
        look(5'b10000, 15, "R7 read index 15 user");
        repeat (3) @(negedge clk);
        chk("R7 counter holds", pc_rdata, 32'h0000_1000);
        // Counter written through general port alone
        put(5'b10011, 15, 32'h0000_2000);
        chk("R7 general write to 15", pc_rdata, 32'h0000_2000);
        // Both in one cycle
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'hDEAD_0000;
        pc_we = 1'b1; pc_wdata = 32'hFEED_0000;
        @(negedge clk);
        wr_en = 1'b0; pc_we = 1'b0; m_reg[30] = 32'hDEAD_0000;
        chk("R8 general port wins", pc_rdata, 32'hDEAD_0000);
        look(5'b10111, 15, "R8 read after conflict");
        // Counter and low register in same cycle
        @(negedge clk);
        mode = 5'b10000; wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h0505_0505;
        pc_we = 1'b1; pc_wdata = 32'h0000_3000;
        @(negedge clk);
        wr_en = 1'b0; pc_we = 1'b0;
        m_reg[5] = 32'h0505_0505; m_reg[30] = 32'h0000_3000;
        chk("R7 counter beside general write", pc_rdata, 32'h0000_3000);
        look(5'b10000, 5, "R7 general write beside counter");
    endtask

    task automatic t_saved();
        for (int mi = 0; mi < 9; mi++) begin
            @(negedge clk);
            mode = MODES[mi]; sts_we = 1'b1; sts_wdata = 32'h5A00_0000 + 32'(mi);
            @(negedge clk);
            sts_we = 1'b0;
            if (ref_sts(MODES[mi]) >= 0) m_sts[ref_sts(MODES[mi])] = 32'h5A00_0000 + 32'(mi);
        end
        for (int mi = 0; mi < 9; mi++) begin
            mode = MODES[mi]; #1;
            if (ref_sts(MODES[mi]) >= 0)
                chk("R9 saved status per mode", sts_rdata, m_sts[ref_sts(MODES[mi])]);
            else if (mi >= 7)
                chk("R10 unknown mode status zero", sts_rdata, 32'h0);
            else
                chk("R9 user/system status zero", sts_rdata, 32'h0);
        end
        sweep("R9 R10 registers unaffected by status writes");
    endtask

    initial begin
        for (int i = 0; i < 31; i++) m_reg[i] = '0;
        for (int i = 0; i < 5; i++)  m_sts[i] = '0;
        rst = 1'b1; mode = 5'b10000; rd_a_idx = '0; rd_b_idx = '0;
        wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        pc_we = 1'b0; pc_wdata = '0; sts_we = 1'b0; sts_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_shared();
        t_banks();
        t_same_cycle();
        t_pc();
        t_saved();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule